// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of an on-chip flash array with a 16-bit data bus. Software drives bus write cycles into it. Each write carries a command code in the low data byte, or page data while a page is being loaded. The block decodes commands of one, two and many cycles. It chooses what a later bus read returns: array words, the status register, or the lock state of a block. It also runs automatic program, erase and lock operations against a small internal array model.

An automatic operation lasts a fixed, parameterised number of clock cycles. While it runs, the ready bit of the status register and the separate ready/busy pin both read 0. Each block has a lock flag. Program, erase and lock commands aimed at a locked block are refused. A page that already holds data cannot be programmed again until its block is erased.

The write port uses valid/ready. `wr_ready` is held at 1, so the block never applies back-pressure. Every beat with `wr_valid` high is taken in that cycle. A beat taken while busy is dropped and reported in the status register. Reads are plain requests, and each is answered one cycle later.

Top module: `flash_cmd_seq`

## Requirements
- R1: Only `wr_data[7:0]` is decoded as the command code, and bits 15:8 are ignored. The codes are FF (read array), 70 (read status), 50 (clear status), 71 (read lock state), 41 (page program), 20 (block erase), A7 (erase all unlocked blocks) and 77 (lock block). D0 is the confirm code. Any other first-cycle code has no effect.
- R2: The read mode selects what a read returns. In array mode it returns the addressed word. In status mode it returns `{8'h00, status}`. In lock mode it returns bit 6 = 1 if the addressed block is unlocked and 0 if it is locked, with all other bits 0. Code 50 clears status bits 5, 4 and 3 and leaves the read mode unchanged.
- R3: Code 41 is followed by PAGE_WORDS data writes. The word slot in the page comes from address bits [IDX_W:1], and the page comes from the address of the last write. The last write starts programming that page with the full 16-bit data.
- R4: Code 20 followed by D0 erases the block selected by the confirm address, which is normally the block's highest address. All of its words become FFFF, and its pages can be programmed again.
- R5: Code A7 followed by D0 erases every unlocked block and leaves locked blocks unchanged.
- R6: Code 77 followed by D0 locks the addressed block. From then on, lock mode reads 0 in bit 6 for that block.
- R7: The write that starts an operation clears status bit 7 and `ready_busy` at its own clock edge. Both return to 1 exactly BUSY_CYCLES edges later, and the read mode becomes status.
- R8: Status mode persists until code FF, code 71 or a flash reset arrives. Code 50 and refused or aborted commands leave it in place.
- R9: A page program or lock command aimed at a locked block sets status bit 4, and so does programming a page that already holds data. An erase of a locked block sets bit 5. A refused command enters status mode and does not go busy.
- R10: A write taken while busy is ignored and sets status bit 3. This includes a write sampled on the very edge at which the operation completes.
- R11: A second-cycle code other than D0 after 20, A7 or 77 aborts the command, sets status bits 5 and 4, and enters status mode.
- R12: `flash_rst` abandons any running operation or pending sequence. It makes the block ready, selects array mode and sets the status to 80. Array content is left as it was.
- R13: `rd_data_valid` is high exactly one cycle after `rd_en`, and `wr_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; sets the array to FFFF and unlocks all blocks |
| flash_rst | input | 1 | Synchronous flash reset of the sequencer |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat accepted (always 1) |
| wr_addr | input | ADDR_W | Byte address of the write; bit 0 is expected to be 0 |
| wr_data | input | 16 | Write data; bits 7:0 carry the command code |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 16 | Read result, registered |
| rd_data_valid | output | 1 | `rd_data` holds the answer to the previous cycle's request |
| ready_busy | output | 1 | 1 = ready, 0 = automatic operation running |

## Verification
Operation completion and an incoming command write can land on the same clock edge. The bench starts a lock operation and counts cycles. It then drives a read-array write that is sampled on exactly the edge at which the busy count expires. The expected result is that the write is dropped: the mode stays status, the status reads 88, and `ready_busy` has just risen. The bench also issues a status read on the cycle right after the start write and expects bit 7 = 0. It checks `ready_busy` one cycle before and one cycle after the expiry edge.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  localparam logic [7:0] CMD_RD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_RD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS = 8'h50;
  localparam logic [7:0] CMD_RD_LOCK    = 8'h71;
  localparam logic [7:0] CMD_PAGE       = 8'h41;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_ERASE_ALL  = 8'hA7;
  localparam logic [7:0] CMD_LOCK       = 8'h77;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;

  localparam int SR_READY    = 7;
  localparam int SR_ERASE_ER = 5;
  localparam int SR_PROG_ER  = 4;
  localparam int SR_BUSY_ER  = 3;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_LOCK} rmode_t;
  typedef enum logic [1:0] {OP_PAGE, OP_ERASE, OP_ERASE_ALL, OP_LOCK} op_t;
  typedef enum logic [2:0] {CS_IDLE, CS_ERASE2, CS_ALL2, CS_LOCK2, CS_LOAD} cstate_t;
endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (clr) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(BUSY_CYCLES);
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) busy <= 1'b0;
    end
  end

  assign done = busy && (cnt == CW'(1)) && !clr;
endmodule

// File: rtl/fseq_store.sv
module fseq_store
  import fseq_pkg::*;
#(
  parameter int NUM_BLOCKS    = 4,
  parameter int PAGES_PER_BLK = 2,
  parameter int PAGE_WORDS    = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pb_we,
  input  logic [$clog2(PAGE_WORDS)-1:0] pb_idx,
  input  logic [15:0] pb_data,
  input  logic commit,
  input  op_t  op,
  input  logic [$clog2(NUM_BLOCKS)-1:0] op_blk,
  input  logic [$clog2(PAGES_PER_BLK)-1:0] op_pg,
  input  logic [$clog2(NUM_BLOCKS*PAGES_PER_BLK*PAGE_WORDS)-1:0] rd_word,
  output logic [15:0] rd_word_data,
  output logic [NUM_BLOCKS-1:0] locked,
  output logic [NUM_BLOCKS*PAGES_PER_BLK-1:0] pg_used
);
  localparam int IDX_W     = $clog2(PAGE_WORDS);
  localparam int NPAGES    = NUM_BLOCKS * PAGES_PER_BLK;
  localparam int BLK_WORDS = PAGES_PER_BLK * PAGE_WORDS;
  localparam int WORDS     = NPAGES * PAGE_WORDS;
  localparam int WA_W      = $clog2(WORDS);
  localparam int BLK_W     = $clog2(NUM_BLOCKS);

  logic [15:0] pbuf [PAGE_WORDS];
  logic [15:0] mem  [WORDS];
  logic [NUM_BLOCKS-1:0] blk_wipe;
  logic [WA_W-1:0] pg_base;

  always_ff @(posedge clk) begin
    if (pb_we) pbuf[pb_idx] <= pb_data;
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign blk_wipe[b] = commit &&
      ((op == OP_ERASE && op_blk == BLK_W'(b)) || (op == OP_ERASE_ALL && !locked[b]));
  end

  assign pg_base = {op_blk, op_pg, {IDX_W{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= 16'hFFFF;
      pg_used <= '0;
      locked  <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (blk_wipe[w / BLK_WORDS]) mem[w] <= 16'hFFFF;
      end
      for (int p = 0; p < NPAGES; p++) begin
        if (blk_wipe[p / PAGES_PER_BLK]) pg_used[p] <= 1'b0;
      end
      if (commit && op == OP_PAGE) begin
        for (int i = 0; i < PAGE_WORDS; i++) mem[pg_base + WA_W'(i)] <= pbuf[i];
        pg_used[{op_blk, op_pg}] <= 1'b1;
      end
      if (commit && op == OP_LOCK) locked[op_blk] <= 1'b1;
    end
  end

  assign rd_word_data = mem[rd_word];
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int NUM_BLOCKS    = 4,
  parameter int PAGES_PER_BLK = 2,
  parameter int PAGE_WORDS    = 128,
  localparam int IDX_W  = $clog2(PAGE_WORDS),
  localparam int PG_W   = $clog2(PAGES_PER_BLK),
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int ADDR_W = BLK_W + PG_W + IDX_W + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flash_rst,
  input  logic wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0] wr_data,
  input  logic busy,
  input  logic done,
  input  logic [NUM_BLOCKS-1:0] locked,
  input  logic [NUM_BLOCKS*PAGES_PER_BLK-1:0] pg_used,
  output logic start,
  output op_t  op,
  output logic [BLK_W-1:0] op_blk,
  output logic [PG_W-1:0] op_pg,
  output logic pb_we,
  output logic [IDX_W-1:0] pb_idx,
  output logic [15:0] pb_data,
  output logic [7:0] sr,
  output rmode_t rmode
);
  cstate_t st, st_n;
  rmode_t rm_n;
  op_t op_n;
  logic [7:0] sr_n;
  logic [BLK_W-1:0] blk_n, a_blk;
  logic [PG_W-1:0] pg_n, a_pg;
  logic [IDX_W-1:0] ld_cnt, cnt_n;
  logic [7:0] code;

  assign code  = wr_data[7:0];
  assign a_blk = wr_addr[ADDR_W-1 -: BLK_W];
  assign a_pg  = wr_addr[IDX_W+PG_W -: PG_W];
  assign pb_idx  = wr_addr[IDX_W:1];
  assign pb_data = wr_data;

  always_comb begin
    start = 1'b0;
    pb_we = 1'b0;
    st_n  = st;
    rm_n  = rmode;
    sr_n  = sr;
    op_n  = op;
    blk_n = op_blk;
    pg_n  = op_pg;
    cnt_n = ld_cnt;
    if (done) sr_n[SR_READY] = 1'b1;
    if (wr_fire) begin
      if (busy) begin
        sr_n[SR_BUSY_ER] = 1'b1;
      end else begin
        case (st)
          CS_IDLE: begin
            case (code)
              CMD_RD_ARRAY:   rm_n = RM_ARRAY;
              CMD_RD_STATUS:  rm_n = RM_STATUS;
              CMD_RD_LOCK:    rm_n = RM_LOCK;
              CMD_CLR_STATUS: sr_n[5:3] = 3'b000;
              CMD_PAGE:       begin st_n = CS_LOAD; cnt_n = '0; end
              CMD_ERASE:      st_n = CS_ERASE2;
              CMD_ERASE_ALL:  st_n = CS_ALL2;
              CMD_LOCK:       st_n = CS_LOCK2;
              default:        ;
            endcase
          end
          CS_ERASE2, CS_ALL2, CS_LOCK2: begin
            st_n = CS_IDLE;
            rm_n = RM_STATUS;
            if (code != CMD_CONFIRM) begin
              sr_n[SR_ERASE_ER] = 1'b1;
              sr_n[SR_PROG_ER]  = 1'b1;
            end else begin
              blk_n = a_blk;
              if (st == CS_ALL2) begin
                op_n  = OP_ERASE_ALL;
                start = 1'b1;
              end else if (locked[a_blk]) begin
                if (st == CS_ERASE2) sr_n[SR_ERASE_ER] = 1'b1;
                else                 sr_n[SR_PROG_ER]  = 1'b1;
              end else begin
                op_n  = (st == CS_ERASE2) ? OP_ERASE : OP_LOCK;
                start = 1'b1;
              end
            end
          end
          CS_LOAD: begin
            pb_we = 1'b1;
            cnt_n = ld_cnt + IDX_W'(1);
            if (ld_cnt == IDX_W'(PAGE_WORDS - 1)) begin
              st_n  = CS_IDLE;
              rm_n  = RM_STATUS;
              blk_n = a_blk;
              pg_n  = a_pg;
              if (locked[a_blk] || pg_used[{a_blk, a_pg}]) begin
                sr_n[SR_PROG_ER] = 1'b1;
              end else begin
                op_n  = OP_PAGE;
                start = 1'b1;
              end
            end
          end
          default: st_n = CS_IDLE;
        endcase
      end
    end
    if (start) sr_n[SR_READY] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= CS_IDLE;
      rmode  <= RM_ARRAY;
      sr     <= 8'h80;
      op     <= OP_PAGE;
      op_blk <= '0;
      op_pg  <= '0;
      ld_cnt <= '0;
    end else if (flash_rst) begin
      st     <= CS_IDLE;
      rmode  <= RM_ARRAY;
      sr     <= 8'h80;
      op     <= OP_PAGE;
      op_blk <= '0;
      op_pg  <= '0;
      ld_cnt <= '0;
    end else begin
      st     <= st_n;
      rmode  <= rm_n;
      sr     <= sr_n;
      op     <= op_n;
      op_blk <= blk_n;
      op_pg  <= pg_n;
      ld_cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int NUM_BLOCKS    = 4,
  parameter int PAGES_PER_BLK = 2,
  parameter int PAGE_WORDS    = 128,
  parameter int BUSY_CYCLES   = 64,
  localparam int IDX_W  = $clog2(PAGE_WORDS),
  localparam int PG_W   = $clog2(PAGES_PER_BLK),
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int ADDR_W = BLK_W + PG_W + IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flash_rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              rd_data_valid,
  output logic              ready_busy
);
  logic wr_fire, tmr_busy, tmr_done, start, pb_we;
  op_t op;
  logic [BLK_W-1:0] op_blk, rd_blk;
  logic [PG_W-1:0] op_pg;
  logic [IDX_W-1:0] pb_idx;
  logic [15:0] pb_data, arr_word;
  logic [7:0] sr;
  rmode_t rmode;
  logic [NUM_BLOCKS-1:0] locked;
  logic [NUM_BLOCKS*PAGES_PER_BLK-1:0] pg_used;

  assign wr_ready   = 1'b1;
  assign wr_fire    = wr_valid && !flash_rst;
  assign ready_busy = !tmr_busy;
  assign rd_blk     = rd_addr[ADDR_W-1 -: BLK_W];

  fseq_ctrl #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLK(PAGES_PER_BLK), .PAGE_WORDS(PAGE_WORDS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flash_rst(flash_rst), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(tmr_busy), .done(tmr_done),
    .locked(locked), .pg_used(pg_used), .start(start), .op(op), .op_blk(op_blk),
    .op_pg(op_pg), .pb_we(pb_we), .pb_idx(pb_idx), .pb_data(pb_data), .sr(sr),
    .rmode(rmode)
  );

  fseq_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(flash_rst), .start(start),
    .busy(tmr_busy), .done(tmr_done)
  );

  fseq_store #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLK(PAGES_PER_BLK), .PAGE_WORDS(PAGE_WORDS)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .pb_we(pb_we), .pb_idx(pb_idx), .pb_data(pb_data),
    .commit(tmr_done), .op(op), .op_blk(op_blk), .op_pg(op_pg),
    .rd_word(rd_addr[ADDR_W-1:1]), .rd_word_data(arr_word),
    .locked(locked), .pg_used(pg_used)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data       <= '0;
      rd_data_valid <= 1'b0;
    end else begin
      rd_data_valid <= rd_en;
      if (rd_en) begin
        case (rmode)
          RM_ARRAY:  rd_data <= arr_word;
          RM_STATUS: rd_data <= {8'h00, sr};
          default:   rd_data <= {9'd0, !locked[rd_blk], 6'd0};
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import fseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       flash_rst,
  input logic       wr_valid,
  input logic       rd_en,
  input logic       rd_data_valid,
  input logic       ready_busy,
  input logic [7:0] sr,
  input rmode_t     rmode
);
  assert_ready_tracks_sr7_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_busy == sr[SR_READY]);

  assert_fall_needs_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_busy) |-> $past(wr_valid && !flash_rst));

  assert_busy_in_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_busy |-> rmode == RM_STATUS);

  assert_busy_write_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_busy && wr_valid && !flash_rst) |=> sr[SR_BUSY_ER]);

  assert_flash_rst_state_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flash_rst |=> (ready_busy && rmode == RM_ARRAY && sr == 8'h80));

  assert_read_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data_valid);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flash_rst(flash_rst), .wr_valid(wr_valid),
  .rd_en(rd_en), .rd_data_valid(rd_data_valid), .ready_busy(ready_busy),
  .sr(sr), .rmode(rmode)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
  localparam int BUSY = 6;
  localparam int PW   = 128;

  logic clk = 1'b0, rst_n = 1'b0, flash_rst = 1'b0;
  logic wr_valid = 1'b0, rd_en = 1'b0;
  logic [10:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic wr_ready, rd_data_valid, ready_busy;
  logic [15:0] rd_data;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_seq #(.NUM_BLOCKS(4), .PAGES_PER_BLK(2), .PAGE_WORDS(PW), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .flash_rst(flash_rst), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_data_valid(rd_data_valid),
    .ready_busy(ready_busy)
  );

  // {write data, read address, expected read} ; walked by one loop (R1, R2)
  localparam logic [47:0] VEC [8] = '{
    {16'h0070, 16'h0000, 16'h0080},
    {16'h00FF, 16'h0000, 16'hFFFF},
    {16'h0071, 16'h0000, 16'h0040},
    {16'h0070, 16'h0000, 16'h0080},
    {16'h0012, 16'h0000, 16'h0080},
    {16'hAB71, 16'h0200, 16'h0040},
    {16'h33FF, 16'h0002, 16'hFFFF},
    {16'h0050, 16'h0004, 16'hFFFF}
  };

  function automatic logic [10:0] ad(int b, int p, int i);
    return 11'((b << 9) | (p << 8) | (i << 1));
  endfunction

  function automatic logic [15:0] pat(int b, int p, int i);
    return 16'((b << 12) | (p << 11) | (i * 5 + 1));
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wait_ready();
    for (int n = 0; n < 100 && !ready_busy; n++) @(negedge clk);
  endtask

  task automatic prog_page(input int b, input int p);
    wr(11'd0, 16'h0041);
    for (int i = 0; i < PW; i++) wr(ad(b, p, i), pat(b, p, i));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset ready", {15'd0, ready_busy}, 16'd1);
    chk("R13 wr_ready", {15'd0, wr_ready}, 16'd1);

    for (int v = 0; v < 8; v++) begin
      wr(11'd0, VEC[v][47:32]);
      rd(VEC[v][26:16], d);
      chk("R1 R2 table", d, VEC[v][15:0]);
    end
    @(negedge clk); rd_en = 1'b1; rd_addr = '0;
    @(negedge clk); rd_en = 1'b0;
    chk("R13 valid after rd_en", {15'd0, rd_data_valid}, 16'd1);
    @(negedge clk);
    chk("R13 valid drops", {15'd0, rd_data_valid}, 16'd0);

    // R3 / R7: program block0 page0 with exact busy timing
    prog_page(0, 0);
    chk("R7 busy at start", {15'd0, ready_busy}, 16'd0);
    rd(11'd0, d);
    chk("R7 sr7 low while busy", d, 16'h0000);
    repeat (3) @(negedge clk);
    chk("R7 busy last cycle", {15'd0, ready_busy}, 16'd0);
    @(negedge clk);
    chk("R7 ready after BUSY", {15'd0, ready_busy}, 16'd1);
    rd(11'd0, d);
    chk("R7 status after done", d, 16'h0080);

    prog_page(1, 0);
    wait_ready();
    wr(11'd0, 16'h00FF);
    rd(ad(0, 0, 5), d);
    chk("R3 word b0p0", d, pat(0, 0, 5));
    rd(ad(1, 0, 127), d);
    chk("R3 word b1p0 last", d, pat(1, 0, 127));

    // R9: reprogram a used page
    prog_page(0, 0);
    chk("R9 refuse no busy", {15'd0, ready_busy}, 16'd1);
    rd(11'd0, d);
    chk("R9 reprogram sr4", d, 16'h0090);
    wr(11'd0, 16'h0050);
    rd(11'd0, d);
    chk("R2 R8 clear keeps status", d, 16'h0080);

    // R6 + R10: lock block1 with a write on the completion edge
    wr(ad(0, 0, 0), 16'h0077);
    wr(ad(1, 1, 127), 16'h00D0);
    chk("R6 lock busy", {15'd0, ready_busy}, 16'd0);
    repeat (4) @(negedge clk);
    wr(11'd0, 16'h00FF);
    chk("R10 ready at collision", {15'd0, ready_busy}, 16'd1);
    rd(11'd0, d);
    chk("R10 collision write dropped", d, 16'h0088);
    wr(11'd0, 16'h0071);
    rd(ad(1, 0, 3), d);
    chk("R6 block1 locked", d, 16'h0000);
    rd(ad(0, 0, 3), d);
    chk("R6 block0 unlocked", d, 16'h0040);
    wr(11'd0, 16'h0050);
    rd(ad(0, 0, 3), d);
    chk("R2 clear keeps lock mode", d, 16'h0040);

    // R9 locked program / erase
    prog_page(1, 1);
    chk("R9 locked program no busy", {15'd0, ready_busy}, 16'd1);
    rd(11'd0, d);
    chk("R9 locked program sr4", d, 16'h0090);
    wr(11'd0, 16'h0050);
    wr(11'd0, 16'h0020);
    wr(ad(1, 1, 127), 16'h00D0);
    rd(11'd0, d);
    chk("R9 locked erase sr5", d, 16'h00A0);
    wr(11'd0, 16'h0050);

    // R11 wrong second code
    wr(11'd0, 16'h0071);
    wr(11'd0, 16'h0020);
    wr(ad(0, 1, 127), 16'h0055);
    rd(11'd0, d);
    chk("R11 bad confirm", d, 16'h00B0);
    wr(11'd0, 16'h0050);

    // R4 erase block0, then reprogram allowed
    wr(11'd0, 16'h0020);
    wr(ad(0, 1, 127), 16'h00D0);
    chk("R4 erase busy", {15'd0, ready_busy}, 16'd0);
    wait_ready();
    wr(11'd0, 16'h00FF);
    rd(ad(0, 0, 5), d);
    chk("R4 erased word", d, 16'hFFFF);
    rd(ad(1, 0, 3), d);
    chk("R4 other block kept", d, pat(1, 0, 3));
    prog_page(0, 0);
    wait_ready();
    rd(11'd0, d);
    chk("R4 reprogram after erase", d, 16'h0080);
    prog_page(2, 0);
    wait_ready();

    // R12 flash reset during erase of block2
    wr(11'd0, 16'h0020);
    wr(ad(2, 1, 127), 16'h00D0);
    @(negedge clk); flash_rst = 1'b1;
    @(negedge clk); flash_rst = 1'b0;
    chk("R12 ready after flash reset", {15'd0, ready_busy}, 16'd1);
    rd(ad(2, 0, 9), d);
    chk("R12 array mode, data kept", d, pat(2, 0, 9));
    repeat (BUSY + 2) @(negedge clk);
    rd(ad(2, 0, 9), d);
    chk("R12 erase abandoned", d, pat(2, 0, 9));
    wr(11'd0, 16'h0070);
    rd(11'd0, d);
    chk("R12 status 80", d, 16'h0080);

    // R5 erase all unlocked
    wr(11'd0, 16'h00A7);
    wr(11'd0, 16'h00D0);
    wait_ready();
    wr(11'd0, 16'h00FF);
    rd(ad(2, 0, 9), d);
    chk("R5 block2 erased", d, 16'hFFFF);
    rd(ad(0, 0, 5), d);
    chk("R5 block0 erased", d, 16'hFFFF);
    rd(ad(1, 0, 3), d);
    chk("R5 locked block1 kept", d, pat(1, 0, 3));

    // R9 lock of an already locked block
    wr(11'd0, 16'h0077);
    wr(ad(1, 0, 0), 16'h00D0);
    rd(11'd0, d);
    chk("R9 relock refused", d, 16'h0090);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule